// File: doc/BRIEF.md
# Hierarchical XOR Burst Encoder

This block re-codes a 256-bit write burst before it goes onto a terminated memory interface, where every transmitted '1' costs termination current. Neighbouring words in vector-style data tend to share their upper bits. XOR-ing them against a common reference therefore clears most of those bits. The burst is treated as four 64-bit elements. The most significant element is the reference, called the base. Each of the other three elements is sent as its XOR with the base.

The base must also reach the receiver, so it is folded in on itself. Its low 32 bits are XOR-ed with its high 32 bits. Inside that high word, the low 16 bits are XOR-ed with the top 16 bits. The top 16 bits pass through untouched.

An all-zero element would otherwise go out as a full copy of the base. Instead it is sent as a fixed low-weight constant. The element value that would normally produce that constant is sent as the base. This swap keeps the code reversible. The output is exactly as wide as the input and carries no flag bits. The result appears one clock after the input is presented.

Top module: `hxor_encoder`

## Requirements
- R1: `out_valid` equals the value of `in_valid` one clock earlier.
- R2: Output bits [255:240] equal input bits [255:240] from the accepted beat.
- R3: Output bits [239:224] equal input [239:224] XOR input [255:240].
- R4: Output bits [223:192] equal input [223:192] XOR input [255:224].
- R5: Each non-base element (bits [191:128], [127:64], [63:0]) that is neither zero nor equal to base XOR C is output as that element XOR the base, where the base is input [255:192].
- R6: A non-base element equal to zero is output as the constant C (default 64'h0000_0000_0000_0200).
- R7: A non-base element equal to base XOR C is output as the base value.
- R8: While `in_valid` is low, `out_data` keeps its previous value.
- R9: During reset, `out_valid` is 0 and `out_data` is all zeros.
- R10: The base element is never remapped. A zero base or a base equal to C is folded only by R2 to R4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_valid | input | 1 | Input beat present |
| in_data | input | 256 | Raw burst; bits [255:192] hold the base element |
| out_valid | output | 1 | Encoded beat present |
| out_data | output | 256 | Encoded burst, same layout as input |

## Verification
A fault in the fold or remap logic shows up on `out_data` in the very next cycle after the beat that triggers it. The faulty field is confined to the element or half-word whose rule failed. A swapped zero/alias rule is visible only on beats containing a zero element or a base-XOR-C element, so the bench drives both on purpose. A corrupted output register shows up either as data changing on an idle cycle or as `out_valid` losing its one-cycle alignment with `in_valid`.

// File: rtl/hxor_pkg.sv
package hxor_pkg;
  localparam int DEF_ELEM_W   = 64;
  localparam int DEF_NUM_ELEM = 4;
  localparam int DEF_LEVELS   = 2;
  localparam logic [DEF_ELEM_W-1:0] DEF_ZERO_CODE = 64'h0000_0000_0000_0200;

  typedef enum logic [1:0] {
    SEL_XOR   = 2'd0,
    SEL_ZERO  = 2'd1,
    SEL_ALIAS = 2'd2
  } remap_sel_e;
endpackage

// File: rtl/hxor_base_fold.sv
module hxor_base_fold #(
  parameter int ELEM_W = hxor_pkg::DEF_ELEM_W,
  parameter int LEVELS = hxor_pkg::DEF_LEVELS
) (
  input  logic [ELEM_W-1:0] base_i,
  output logic [ELEM_W-1:0] base_o
);
  localparam int TOP_W = ELEM_W >> LEVELS;

  // Each level folds the lower half of a shrinking top window onto its upper half.
  for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
    localparam int WIN = ELEM_W >> l;
    localparam int LO  = ELEM_W - WIN;
    localparam int HW  = WIN / 2;
    assign base_o[LO+HW-1:LO] = base_i[LO+HW-1:LO] ^ base_i[LO+WIN-1:LO+HW];
  end

  assign base_o[ELEM_W-1:ELEM_W-TOP_W] = base_i[ELEM_W-1:ELEM_W-TOP_W];
endmodule

// File: rtl/hxor_elem_remap.sv
module hxor_elem_remap
  import hxor_pkg::*;
#(
  parameter int ELEM_W = DEF_ELEM_W,
  parameter logic [ELEM_W-1:0] ZERO_CODE = DEF_ZERO_CODE
) (
  input  logic [ELEM_W-1:0] base_i,
  input  logic [ELEM_W-1:0] elem_i,
  output logic [ELEM_W-1:0] code_o
);
  logic [ELEM_W-1:0] alias_val;
  remap_sel_e        sel;

  assign alias_val = base_i ^ ZERO_CODE;

  always_comb begin
    if (elem_i == '0)
      sel = SEL_ZERO;
    else if (elem_i == alias_val)
      sel = SEL_ALIAS;
    else
      sel = SEL_XOR;
  end

  always_comb begin
    unique case (sel)
      SEL_ZERO:  code_o = ZERO_CODE;
      SEL_ALIAS: code_o = base_i;
      default:   code_o = elem_i ^ base_i;
    endcase
  end
endmodule

// File: rtl/hxor_encoder.sv
module hxor_encoder
  import hxor_pkg::*;
#(
  parameter int ELEM_W   = DEF_ELEM_W,
  parameter int NUM_ELEM = DEF_NUM_ELEM,
  parameter int LEVELS   = DEF_LEVELS,
  parameter logic [ELEM_W-1:0] ZERO_CODE = DEF_ZERO_CODE
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          in_valid,
  input  logic [ELEM_W*NUM_ELEM-1:0]    in_data,
  output logic                          out_valid,
  output logic [ELEM_W*NUM_ELEM-1:0]    out_data
);
  localparam int BURST_W = ELEM_W * NUM_ELEM;
  localparam int BASE_LO = BURST_W - ELEM_W;

  if (ZERO_CODE == '0) begin : g_bad_code
    $error("hxor_encoder: ZERO_CODE must be non-zero");
  end

  logic [ELEM_W-1:0]  base_raw;
  logic [BURST_W-1:0] enc_d;
  logic               valid_d;
  logic [BURST_W-1:0] data_q;
  logic               valid_q;

  assign base_raw = in_data[BURST_W-1:BASE_LO];

  hxor_base_fold #(
    .ELEM_W (ELEM_W),
    .LEVELS (LEVELS)
  ) u_fold (
    .base_i (base_raw),
    .base_o (enc_d[BURST_W-1:BASE_LO])
  );

  for (genvar k = 1; k < NUM_ELEM; k++) begin : g_elem
    localparam int HI = BURST_W - k*ELEM_W - 1;
    hxor_elem_remap #(
      .ELEM_W    (ELEM_W),
      .ZERO_CODE (ZERO_CODE)
    ) u_remap (
      .base_i (base_raw),
      .elem_i (in_data[HI -: ELEM_W]),
      .code_o (enc_d[HI -: ELEM_W])
    );
  end

  // Next state
  assign valid_d = in_valid;

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else begin
      valid_q <= valid_d;
      if (in_valid) data_q <= enc_d;
    end
  end

  assign out_valid = valid_q;
  assign out_data  = data_q;
endmodule

// File: rtl/hxor_encoder_chk.sv
module hxor_encoder_chk #(
  parameter int ELEM_W   = 64,
  parameter int NUM_ELEM = 4,
  parameter logic [ELEM_W-1:0] ZERO_CODE = 64'h200
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       in_valid,
  input logic [ELEM_W*NUM_ELEM-1:0] in_data,
  input logic                       out_valid,
  input logic [ELEM_W*NUM_ELEM-1:0] out_data
);
  localparam int BW = ELEM_W * NUM_ELEM;
  localparam int H  = ELEM_W / 2;
  localparam int Q  = ELEM_W / 4;
  localparam int E1 = BW - ELEM_W - 1;

  // R1
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  // R1
  valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  // R2
  base_top_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_data[BW-1 -: Q] == $past(in_data[BW-1 -: Q]));
  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_data));
  // R6
  zero_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_data[E1 -: ELEM_W] == '0) |=> out_data[E1 -: ELEM_W] == ZERO_CODE);
  // R7
  alias_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_data[E1 -: ELEM_W] == (in_data[BW-1 -: ELEM_W] ^ ZERO_CODE))
    |=> out_data[E1 -: ELEM_W] == $past(in_data[BW-1 -: ELEM_W]));
  // R4
  base_low_fold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_data[BW-ELEM_W+H-1 -: H] ==
      ($past(in_data[BW-ELEM_W+H-1 -: H]) ^ $past(in_data[BW-1 -: H])));
  // R9
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |-> (!out_valid && out_data == '0));
endmodule

bind hxor_encoder hxor_encoder_chk #(
  .ELEM_W    (ELEM_W),
  .NUM_ELEM  (NUM_ELEM),
  .ZERO_CODE (ZERO_CODE)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_data   (in_data),
  .out_valid (out_valid),
  .out_data  (out_data)
);

// File: tb/hxor_encoder_tb.sv
`timescale 1ns/1ps
module hxor_encoder_tb;
  localparam logic [63:0] C = 64'h0000_0000_0000_0200;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [255:0] in_data = '0;
  logic         out_valid;
  logic [255:0] out_data;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // model state
  logic         exp_valid;
  logic [255:0] exp_data;

  always #2.5 clk = ~clk;

  hxor_encoder u_dut (
    .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .in_data (in_data),
    .out_valid (out_valid), .out_data (out_data)
  );

  function automatic logic [63:0] elem_of(logic [255:0] d, int k);
    return d[255 - 64*k -: 64];
  endfunction

  task automatic check(string tag, logic [255:0] act, logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Drive one cycle and compare every field against the model afterwards.
  task automatic step(logic v, logic [255:0] d);
    logic [63:0] b;
    logic [63:0] e;
    logic [63:0] r;
    logic [255:0] prev;
    @(negedge clk);
    in_valid = v;
    in_data  = d;
    prev = exp_data;
    exp_valid = v;
    if (v) begin
      b = elem_of(d, 0);
      exp_data[255:240] = b[63:48];
      exp_data[239:224] = b[47:32] ^ b[63:48];
      exp_data[223:192] = b[31:0]  ^ b[63:32];
      for (int k = 1; k < 4; k++) begin
        e = elem_of(d, k);
        if (e == 64'd0) r = C;
        else if (e == (b ^ C)) r = b;
        else r = e ^ b;
        exp_data[255 - 64*k -: 64] = r;
      end
    end
    @(posedge clk);
    #1;
    check("R1 valid", {255'd0, out_valid}, {255'd0, exp_valid});
    if (!v) check("R8 hold", out_data, prev);
    check("R2 base top16", {240'd0, out_data[255:240]}, {240'd0, exp_data[255:240]});
    check("R3 base mid16", {240'd0, out_data[239:224]}, {240'd0, exp_data[239:224]});
    check("R4 base low32", {224'd0, out_data[223:192]}, {224'd0, exp_data[223:192]});
    if (v) begin
      for (int k = 1; k < 4; k++) begin
        e = elem_of(d, k);
        if (e == 64'd0)
          check($sformatf("R6 zero elem %0d", k), {192'd0, elem_of(out_data, k)}, {192'd0, elem_of(exp_data, k)});
        else if (e == (elem_of(d, 0) ^ C))
          check($sformatf("R7 alias elem %0d", k), {192'd0, elem_of(out_data, k)}, {192'd0, elem_of(exp_data, k)});
        else
          check($sformatf("R5 xor elem %0d", k), {192'd0, elem_of(out_data, k)}, {192'd0, elem_of(exp_data, k)});
      end
    end else begin
      check("R8 hold elems", out_data, exp_data);
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    logic [63:0] b;
    exp_valid = 1'b0;
    exp_data  = '0;
    repeat (3) @(posedge clk);
    #1;
    check("R9 reset valid", {255'd0, out_valid}, 256'd0);
    check("R9 reset data", out_data, 256'd0);
    @(negedge clk);
    rst_n = 1'b1;

    // similar neighbours
    b = 64'h4049_0FDB_40DF_5B7E;
    step(1'b1, {b, 64'h4049_0FDB_40DF_5B7F, 64'h4049_0FDB_41DE_9E66, 64'h4049_0FDC_40E2_6A00});
    // idle holds
    step(1'b0, {4{64'hFFFF_0000_FFFF_0000}});
    step(1'b0, '0);
    // zero elements
    step(1'b1, {b, 64'd0, 64'h1234_5678_9ABC_DEF0, 64'd0});
    // alias elements
    step(1'b1, {b, b ^ C, 64'd0, b ^ C});
    // R10: zero base, elements 0 / C
    step(1'b1, {64'd0, 64'd0, C, 64'h8000_0000_0000_0001});
    // R10: base equal to C
    step(1'b1, {C, 64'd0, 64'd0, C});
    // all ones
    step(1'b1, {256{1'b1}});
    // base equal to each element
    step(1'b1, {4{b}});
    step(1'b0, '0);
    for (int i = 0; i < 300; i++) begin
      logic [255:0] d;
      d = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
      if (i % 7 == 1) d[191:128] = 64'd0;
      if (i % 5 == 2) d[127:64] = d[255:192] ^ C;
      if (i % 11 == 3) d[63:0] = d[255:192] ^ 64'h0000_0000_0000_0001;
      step((i % 4) != 3, d);
    end
    // reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R9 async reset valid", {255'd0, out_valid}, 256'd0);
    check("R9 async reset data", out_data, 256'd0);
    exp_valid = 1'b0;
    exp_data = '0;
    @(negedge clk);
    rst_n = 1'b1;
    step(1'b0, '0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule